// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Clip Flag

This block is a 32-bit arithmetic unit that clips results instead of letting them wrap. It covers signed and unsigned add and subtract, a signed doubling step, and the clamping of a value to a chosen bit width. The width clamp is applied either to the whole word or to two independent 16-bit halves. A 4-bit opcode picks the operation and a 5-bit width operand sets the clamp width. One further opcode returns the ordinary wrapped sum but still reports signed overflow.

Results and the per-operation clip indication are combinational. A single sticky flag records that some operation clipped. It is updated on a clock edge only while the valid strobe is high. Once set, it stays set until a dedicated clear input drops it. A pipeline drives one operation per cycle, raises valid for the ones that count, and polls the flag after a run of operations.

Top module: `sat_unit`

## Requirements
- R1: Opcode encoding: 0 wrapping add, 1 signed saturating add, 2 signed saturating subtract, 3 unsigned saturating add, 4 unsigned saturating subtract, 5 signed doubling, 6 signed width clamp of the word, 7 signed width clamp per halfword, 8 unsigned width clamp of the word, 9 unsigned width clamp per halfword. Opcode 0 returns opA+opB modulo 2^32 and raises clipNow exactly on signed overflow.
- R2: Signed add overflows when the operands share a sign and the sum's sign differs from opA. Signed subtract overflows when the operands differ in sign and the difference's sign differs from opA. On overflow the result is 0x7FFFFFFF for non-negative opA and 0x80000000 for negative opA, with clipNow high.
- R3: Unsigned add returns 0xFFFFFFFF with clipNow when the wrapped sum is below opA. Unsigned subtract returns 0 with clipNow when the wrapped difference is above opA.
- R4: Doubling of opA gives 0x7FFFFFFF for opA >= 0x40000000 and 0x80000000 for opA <= 0xC0000000 (both signed), each with clipNow. Any other value gives opA shifted left by one.
- R5: Signed word clamp to width N (satWidth): if opA>>>N is positive the result is (1<<N)-1, if it is below -1 the result is ~((1<<N)-1), each with clipNow; otherwise opA passes unchanged.
- R6: Unsigned word clamp to width N: negative opA gives 0 and opA above (1<<N)-1 gives (1<<N)-1, each with clipNow; otherwise opA passes unchanged.
- R7: Halfword clamps sign-extend opA[15:0] and opA[31:16], clamp each as in R5/R6, and place the low 16 result bits of each in the matching half of the result. clipNow is high if either half clipped.
- R8: Opcodes 10 to 15 give a zero result with clipNow low. opB is ignored by opcodes 5 to 9.
- R9: stickyFlag is set at a rising clock edge when valid and clipNow are both high. A clipping operation with valid low leaves it unchanged.
- R10: Once set, stickyFlag holds through any operations and is cleared only by clearFlag at a clock edge. When a valid clipping operation and clearFlag occur together, the flag ends set.
- R11: An active-low reset (rstN) clears stickyFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opSel | input | 4 | Operation code (see R1) |
| opA | input | 32 | First operand, or the value to clamp or double |
| opB | input | 32 | Second operand for add and subtract |
| satWidth | input | 5 | Clamp width N for the width operations |
| valid | input | 1 | Current operation counts toward the sticky flag |
| clearFlag | input | 1 | Clears the sticky flag at the clock edge |
| result | output | 32 | Combinational result |
| clipNow | output | 1 | Combinational: the current operation clipped |
| stickyFlag | output | 1 | Registered sticky clip flag |

## Verification
The hardest case to reach from the ports is the cycle in which a valid clipping operation and a clear arrive together. The flag must already be set when that cycle starts, or the priority rule shows nothing. The stimulus first sets the flag with a valid overflow, holds it across non-clipping operations, and only then drives the coincident set and clear before a clear on its own. The halfword clamps are driven with one lane clipping, both lanes clipping and neither clipping, so that the clip of each lane is seen separately.

// File: rtl/sat_unit_pkg.sv
package sat_unit_pkg;

  typedef enum logic [3:0] {
    OP_WRAP_ADD = 4'd0,
    OP_SADD     = 4'd1,
    OP_SSUB     = 4'd2,
    OP_UADD     = 4'd3,
    OP_USUB     = 4'd4,
    OP_DOUBLE   = 4'd5,
    OP_SCLAMP_W = 4'd6,
    OP_SCLAMP_H = 4'd7,
    OP_UCLAMP_W = 4'd8,
    OP_UCLAMP_H = 4'd9
  } satOp_e;

  typedef enum logic [1:0] {
    UNIT_NONE   = 2'd0,
    UNIT_ADDSUB = 2'd1,
    UNIT_DOUBLE = 2'd2,
    UNIT_CLAMP  = 2'd3
  } unitSel_e;

  typedef struct packed {
    unitSel_e unit;
    logic     subtract;
    logic     signedMode;
    logic     wrapOnly;
    logic     halfMode;
  } satStrobe_t;

endpackage

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_unit_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opSel,
  input  logic            valid,
  input  logic            clearFlag,
  input  logic            clipNow,
  output satStrobe_t      strobe,
  output logic            stickyFlag
);

  always_comb begin
    strobe = '{unit: UNIT_NONE, subtract: 1'b0, signedMode: 1'b0,
               wrapOnly: 1'b0, halfMode: 1'b0};
    case (opSel)
      OP_WRAP_ADD: begin
        strobe.unit       = UNIT_ADDSUB;
        strobe.signedMode = 1'b1;
        strobe.wrapOnly   = 1'b1;
      end
      OP_SADD: begin
        strobe.unit       = UNIT_ADDSUB;
        strobe.signedMode = 1'b1;
      end
      OP_SSUB: begin
        strobe.unit       = UNIT_ADDSUB;
        strobe.signedMode = 1'b1;
        strobe.subtract   = 1'b1;
      end
      OP_UADD: strobe.unit = UNIT_ADDSUB;
      OP_USUB: begin
        strobe.unit     = UNIT_ADDSUB;
        strobe.subtract = 1'b1;
      end
      OP_DOUBLE: begin
        strobe.unit       = UNIT_DOUBLE;
        strobe.signedMode = 1'b1;
      end
      OP_SCLAMP_W: begin
        strobe.unit       = UNIT_CLAMP;
        strobe.signedMode = 1'b1;
      end
      OP_SCLAMP_H: begin
        strobe.unit       = UNIT_CLAMP;
        strobe.signedMode = 1'b1;
        strobe.halfMode   = 1'b1;
      end
      OP_UCLAMP_W: strobe.unit = UNIT_CLAMP;
      OP_UCLAMP_H: begin
        strobe.unit     = UNIT_CLAMP;
        strobe.halfMode = 1'b1;
      end
      default: strobe.unit = UNIT_NONE;
    endcase
  end

  // set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN)                 stickyFlag <= 1'b0;
    else if (valid && clipNow) stickyFlag <= 1'b1;
    else if (clearFlag)        stickyFlag <= 1'b0;
  end

endmodule

// File: rtl/sat_datapath.sv
module sat_datapath
  import sat_unit_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = $clog2(WORD_W)
) (
  input  satStrobe_t         strobe,
  input  logic [WORD_W-1:0]  opA,
  input  logic [WORD_W-1:0]  opB,
  input  logic [SHIFT_W-1:0] satWidth,
  output logic [WORD_W-1:0]  result,
  output logic               clipNow
);

  localparam int HALF_W = WORD_W / 2;
  localparam int LANES  = 2;
  localparam int MSB    = WORD_W - 1;
  localparam logic [WORD_W-1:0] POS_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] NEG_MAX = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic signed [WORD_W-1:0] QUARTER    = WORD_W'(1) << (WORD_W - 2);
  localparam logic signed [WORD_W-1:0] NEG_QUARTER = -QUARTER;

  // {clip, value}
  function automatic logic [WORD_W:0] clampFn(input logic [WORD_W-1:0] v,
                                              input logic [SHIFT_W-1:0] n,
                                              input logic isSigned);
    logic [WORD_W-1:0]        mask;
    logic signed [WORD_W-1:0] top;
    mask = (WORD_W'(1) << n) - WORD_W'(1);
    top  = $signed(v) >>> n;
    if (isSigned) begin
      if (top > 0)       clampFn = {1'b1, mask};
      else if (top < -1) clampFn = {1'b1, ~mask};
      else               clampFn = {1'b0, v};
    end else begin
      if (v[MSB])        clampFn = {1'b1, {WORD_W{1'b0}}};
      else if (v > mask) clampFn = {1'b1, mask};
      else               clampFn = {1'b0, v};
    end
  endfunction

  function automatic logic [HALF_W:0] clampHalfFn(input logic [HALF_W-1:0] h,
                                                 input logic [SHIFT_W-1:0] n,
                                                 input logic isSigned);
    logic [WORD_W:0] full;
    full = clampFn({{HALF_W{h[HALF_W-1]}}, h}, n, isSigned);
    clampHalfFn = {full[WORD_W], full[HALF_W-1:0]};
  endfunction

  // add / subtract
  logic [WORD_W-1:0] bOper, rawSum;
  logic              signOvf, unsOvf;
  assign bOper   = strobe.subtract ? ~opB : opB;
  assign rawSum  = opA + bOper + WORD_W'(strobe.subtract);
  assign signOvf = (strobe.subtract ? (opA[MSB] != opB[MSB]) : (opA[MSB] == opB[MSB]))
                   && (rawSum[MSB] != opA[MSB]);
  assign unsOvf  = strobe.subtract ? (rawSum > opA) : (rawSum < opA);

  // doubling
  logic dblHigh, dblLow;
  assign dblHigh = $signed(opA) >= QUARTER;
  assign dblLow  = $signed(opA) <= NEG_QUARTER;

  // width clamp, whole word
  logic [WORD_W:0] wordClamp;
  assign wordClamp = clampFn(opA, satWidth, strobe.signedMode);

  // width clamp, per lane
  logic [HALF_W-1:0] laneRes  [LANES];
  logic [LANES-1:0]  laneClip;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign {laneClip[g], laneRes[g]} =
      clampHalfFn(opA[g*HALF_W +: HALF_W], satWidth, strobe.signedMode);
  end

  always_comb begin
    result  = '0;
    clipNow = 1'b0;
    case (strobe.unit)
      UNIT_ADDSUB: begin
        if (strobe.wrapOnly) begin
          result  = rawSum;
          clipNow = signOvf;
        end else if (strobe.signedMode) begin
          clipNow = signOvf;
          result  = signOvf ? (opA[MSB] ? NEG_MAX : POS_MAX) : rawSum;
        end else begin
          clipNow = unsOvf;
          result  = unsOvf ? (strobe.subtract ? '0 : '1) : rawSum;
        end
      end
      UNIT_DOUBLE: begin
        clipNow = dblHigh || dblLow;
        result  = dblHigh ? POS_MAX : (dblLow ? NEG_MAX : {opA[WORD_W-2:0], 1'b0});
      end
      UNIT_CLAMP: begin
        if (strobe.halfMode) begin
          result  = {laneRes[1], laneRes[0]};
          clipNow = |laneClip;
        end else begin
          result  = wordClamp[WORD_W-1:0];
          clipNow = wordClamp[WORD_W];
        end
      end
      default: begin
        result  = '0;
        clipNow = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sat_unit.sv
module sat_unit
  import sat_unit_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int OP_W    = 4,
  parameter int SHIFT_W = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OP_W-1:0]    opSel,
  input  logic [WORD_W-1:0]  opA,
  input  logic [WORD_W-1:0]  opB,
  input  logic [SHIFT_W-1:0] satWidth,
  input  logic               valid,
  input  logic               clearFlag,
  output logic [WORD_W-1:0]  result,
  output logic               clipNow,
  output logic               stickyFlag
);

  satStrobe_t strobe;

  sat_ctrl #(.OP_W(OP_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .opSel(opSel), .valid(valid),
    .clearFlag(clearFlag), .clipNow(clipNow),
    .strobe(strobe), .stickyFlag(stickyFlag)
  );

  sat_datapath #(.WORD_W(WORD_W), .SHIFT_W(SHIFT_W)) dp_i (
    .strobe(strobe), .opA(opA), .opB(opB), .satWidth(satWidth),
    .result(result), .clipNow(clipNow)
  );

endmodule

// File: rtl/sat_unit_chk.sv
module sat_unit_chk #(
  parameter int WORD_W  = 32,
  parameter int OP_W    = 4,
  parameter int SHIFT_W = $clog2(WORD_W)
) (
  input logic               clk,
  input logic               rstN,
  input logic [OP_W-1:0]    opSel,
  input logic [WORD_W-1:0]  opA,
  input logic [WORD_W-1:0]  opB,
  input logic [SHIFT_W-1:0] satWidth,
  input logic               valid,
  input logic               clearFlag,
  input logic [WORD_W-1:0]  result,
  input logic               clipNow,
  input logic               stickyFlag
);

  p_set_on_clip_r9: assert property (@(posedge clk) disable iff (!rstN)
    (valid && clipNow) |=> stickyFlag);

  p_rise_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stickyFlag) |-> $past(valid && clipNow));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stickyFlag && !clearFlag) |=> stickyFlag);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (clearFlag && !(valid && clipNow)) |=> !stickyFlag);

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opSel >= OP_W'(10)) |-> (result == '0 && !clipNow));

  p_uadd_ceiling_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_W'(3) && clipNow) |-> (result == '1));

  p_usub_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_W'(4) && clipNow) |-> (result == '0));

endmodule

bind sat_unit sat_unit_chk #(.WORD_W(WORD_W), .OP_W(OP_W), .SHIFT_W(SHIFT_W)) chk_i (
  .clk(clk), .rstN(rstN), .opSel(opSel), .opA(opA), .opB(opB),
  .satWidth(satWidth), .valid(valid), .clearFlag(clearFlag),
  .result(result), .clipNow(clipNow), .stickyFlag(stickyFlag)
);

// File: tb/sat_unit_tb.sv
module sat_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [4:0]  satWidth = '0;
  logic        valid = 1'b0, clearFlag = 1'b0;
  logic [31:0] result;
  logic        clipNow, stickyFlag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sat_unit dut_i (
    .clk(clk), .rstN(rstN), .opSel(opSel), .opA(opA), .opB(opB),
    .satWidth(satWidth), .valid(valid), .clearFlag(clearFlag),
    .result(result), .clipNow(clipNow), .stickyFlag(stickyFlag)
  );

  // {op, width, a, b, expected result, expected clip}
  localparam int NV = 30;
  localparam logic [105:0] VECS [NV] = '{
    {4'd0, 5'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1},
    {4'd0, 5'd0, 32'h00000002, 32'h00000003, 32'h00000005, 1'b0},
    {4'd1, 5'd0, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1},
    {4'd1, 5'd0, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1},
    {4'd1, 5'd0, 32'h00000005, 32'h00000007, 32'h0000000C, 1'b0},
    {4'd2, 5'd0, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1},
    {4'd2, 5'd0, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1},
    {4'd2, 5'd0, 32'h0000000A, 32'h00000003, 32'h00000007, 1'b0},
    {4'd3, 5'd0, 32'hFFFFFFF0, 32'h00000020, 32'hFFFFFFFF, 1'b1},
    {4'd3, 5'd0, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0},
    {4'd4, 5'd0, 32'h00000003, 32'h00000005, 32'h00000000, 1'b1},
    {4'd4, 5'd0, 32'h00000009, 32'h00000004, 32'h00000005, 1'b0},
    {4'd5, 5'd0, 32'h40000000, 32'h12345678, 32'h7FFFFFFF, 1'b1},
    {4'd5, 5'd0, 32'h3FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFE, 1'b0},
    {4'd5, 5'd0, 32'hC0000000, 32'h00000000, 32'h80000000, 1'b1},
    {4'd5, 5'd0, 32'hC0000001, 32'h00000000, 32'h80000002, 1'b0},
    {4'd6, 5'd7, 32'h000000C8, 32'hFFFFFFFF, 32'h0000007F, 1'b1},
    {4'd6, 5'd7, 32'hFFFFFED4, 32'h00000000, 32'hFFFFFF80, 1'b1},
    {4'd6, 5'd7, 32'h00000064, 32'h00000000, 32'h00000064, 1'b0},
    {4'd6, 5'd7, 32'hFFFFFF9C, 32'h00000000, 32'hFFFFFF9C, 1'b0},
    {4'd8, 5'd8, 32'hFFFFFFFB, 32'h00000000, 32'h00000000, 1'b1},
    {4'd8, 5'd8, 32'h0000012C, 32'h00000000, 32'h000000FF, 1'b1},
    {4'd8, 5'd8, 32'h000000FF, 32'hAAAAAAAA, 32'h000000FF, 1'b0},
    {4'd7, 5'd7, 32'h0100FF00, 32'h00000000, 32'h007FFF80, 1'b1},
    {4'd7, 5'd7, 32'h0010FFF0, 32'h00000000, 32'h0010FFF0, 1'b0},
    {4'd9, 5'd8, 32'h0120FFFF, 32'h00000000, 32'h00FF0000, 1'b1},
    {4'd9, 5'd8, 32'h00050006, 32'h00000000, 32'h00050006, 1'b0},
    {4'd9, 5'd8, 32'h00050200, 32'h00000000, 32'h000500FF, 1'b1},
    {4'd12, 5'd0, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 1'b0},
    {4'd15, 5'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0}
  };

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0:       reqOf = "R1";
      4'd1, 4'd2: reqOf = "R2";
      4'd3, 4'd4: reqOf = "R3";
      4'd5:       reqOf = "R4";
      4'd6:       reqOf = "R5";
      4'd8:       reqOf = "R6";
      4'd7, 4'd9: reqOf = "R7";
      default:    reqOf = "R8";
    endcase
  endfunction

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic v, input logic clr);
    opSel = op; opA = a; opB = b; satWidth = '0; valid = v; clearFlag = clr;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R11", "sticky in reset", 32'(stickyFlag), 32'd0);
    rstN = 1'b1;
    tick();
    checkVal("R11", "sticky after reset", 32'(stickyFlag), 32'd0);

    // table walk, valid low so the flag must stay clear
    for (int i = 0; i < NV; i++) begin
      opSel = VECS[i][105:102]; satWidth = VECS[i][101:97];
      opA = VECS[i][96:65]; opB = VECS[i][64:33];
      valid = 1'b0; clearFlag = 1'b0;
      #2;
      checkVal(reqOf(opSel), "result", result, VECS[i][32:1]);
      checkVal(reqOf(opSel), "clip", 32'(clipNow), 32'(VECS[i][0]));
    end
    tick();
    checkVal("R9", "clips with valid low left flag", 32'(stickyFlag), 32'd0);

    // R9: valid but no clip
    drive(4'd1, 32'd5, 32'd7, 1'b1, 1'b0);
    tick();
    checkVal("R9", "valid no clip", 32'(stickyFlag), 32'd0);
    // R9: valid clip sets
    drive(4'd1, 32'h7FFFFFFF, 32'd1, 1'b1, 1'b0);
    tick();
    checkVal("R9", "valid clip sets", 32'(stickyFlag), 32'd1);
    // R10: holds over non-clipping ops
    drive(4'd3, 32'd1, 32'd2, 1'b1, 1'b0);
    repeat (3) tick();
    checkVal("R10", "held over clean ops", 32'(stickyFlag), 32'd1);
    // R10: coincident set and clear keeps it set
    drive(4'd4, 32'd0, 32'd1, 1'b1, 1'b1);
    tick();
    checkVal("R10", "set beats clear", 32'(stickyFlag), 32'd1);
    // R10: clear alone
    drive(4'd4, 32'd0, 32'd1, 1'b0, 1'b1);
    tick();
    checkVal("R10", "clear drops flag", 32'(stickyFlag), 32'd0);
    // R10: set via halfword clamp, clear with valid clean op
    drive(4'd9, 32'h00050200, 32'd0, 1'b1, 1'b0);
    satWidth = 5'd8;
    tick();
    checkVal("R7", "lane clip sets flag", 32'(stickyFlag), 32'd1);
    drive(4'd1, 32'd1, 32'd1, 1'b1, 1'b1);
    tick();
    checkVal("R10", "clear with clean valid op", 32'(stickyFlag), 32'd0);
    // R11: reset clears a set flag
    drive(4'd5, 32'h40000000, 32'd0, 1'b1, 1'b0);
    tick();
    checkVal("R4", "doubling clip sets flag", 32'(stickyFlag), 32'd1);
    drive(4'd0, 32'd0, 32'd0, 1'b0, 1'b0);
    rstN = 1'b0;
    tick();
    checkVal("R11", "reset clears flag", 32'(stickyFlag), 32'd0);
    rstN = 1'b1;
    tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule